// File: doc/BRIEF.md
# Chip-Select Bank Address Decoder

This block turns a 32-bit address presented on an external system bus into one of eight chip-select lines. Each chip-select is driven by a bank register. The register holds a base address, a compare mask and an enable bit, so a bank claims one power-of-two sized window that is aligned to its own size. The smallest window is 128 KiB. Software programs the bank registers through a small word-wide write/read port.

Two reset-time and legacy behaviours are built in. First, a boot-swap strap is captured while reset is held. When the strap is set, the roles of chip-selects 0 and 1 are exchanged, and the reset value of bank 0 tells software that the swap happened. Second, a bank 0 or bank 1 register that holds all zeros claims every address, whatever its enable bit says.

The decode result is registered. It appears one cycle after the address strobe, as a one-hot (or all-low) chip-select vector together with a no-match flag.

Top module: `csdec_top`

## Requirements
- R1: Bank register i sits at byte offset 0x100 + 0x10·i of the register port. A write there stores the data with bit 16 forced to zero. A read returns the stored value. Any other offset reads as zero, and writes to it change no register.
- R2: The bank register fields are: bits [31:17] hold the base, bits [15:1] hold the mask, and bit 0 is the enable. An enabled bank matches when, for every mask bit k (1..15) that is set, address bit k+16 equals register bit k+16. Address bits [16:0] and address bits whose mask bit is clear are ignored.
- R3: A bank whose register is nonzero and whose bit 0 is clear never matches.
- R4: A bank 0 or bank 1 register equal to 0x00000000 matches every address, even though its enable bit is clear.
- R5: The strap is captured on every clock while reset is low and held after reset. When it is 1, bank 0's register drives chip-select 1 and bank 1's register drives chip-select 0. All other banks map straight through.
- R6: Reset values are as follows. Bank 0 reads 0x00000001 when the strap is 0 and 0x00000000 when it is 1. Bank 1 reads 0xFFFEFFFF. Banks 2..7 read 0. During reset all chip-selects and the no-match flag are low.
- R7: When several chip-selects match, only the lowest-numbered one is driven, so the chip-select vector is always one-hot or zero.
- R8: After a strobed access that no bank claims, the no-match flag is high and all chip-selects are low.
- R9: The outputs reflect the address strobed in the previous cycle. After a cycle without a strobe, every chip-select and the no-match flag are low.
- R10: An access strobed in the same cycle as a register write is decoded with the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_swap | input | 1 | Boot-swap strap, captured during reset |
| bus_valid | input | 1 | Address strobe |
| bus_addr | input | 32 | Bus address to decode |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| cs_o | output | 8 | Registered one-hot chip-selects |
| no_match_o | output | 1 | Registered flag: the last strobed address was not claimed |

## Verification
A wrong stored bank word or a wrong stored strap shows up at the ports through two paths. It appears in the read data in the same cycle. It also appears in the chip-select vector one clock after the next strobe whose address that bank would claim, or whose claim it would have lost to a lower-numbered chip-select. A stale or lost write is therefore exposed one cycle after any access that falls inside the affected window. A broken priority or swap shows up in the first overlapping access.

// File: rtl/csdec_pkg.sv
package csdec_pkg;

    localparam int WORD_W  = 32;
    localparam int FIELD_W = 15;
    localparam int GRAN_LSB = 17;

    // bank word: [31:17] base, [16] reserved, [15:1] mask, [0] enable
    typedef struct packed {
        logic [FIELD_W-1:0] base;
        logic               rsvd;
        logic [FIELD_W-1:0] mask;
        logic               en;
    } bank_reg_t;

    localparam logic [WORD_W-1:0] STORE_MASK = 32'hFFFE_FFFF;
    localparam logic [WORD_W-1:0] BANK1_RST  = 32'hFFFE_FFFF;

    function automatic bank_reg_t to_bank(input logic [WORD_W-1:0] w);
        return bank_reg_t'(w & STORE_MASK);
    endfunction

    function automatic logic window_hit(input bank_reg_t b,
                                        input logic [WORD_W-1:0] addr);
        logic [FIELD_W-1:0] diff;
        diff = (addr[WORD_W-1:GRAN_LSB] ^ b.base) & b.mask;
        return (diff == '0);
    endfunction

endpackage

// File: rtl/csdec_regs.sv
module csdec_regs
    import csdec_pkg::*;
#(
    parameter int NUM_BANKS   = 8,
    parameter int REG_AW      = 12,
    parameter int BANK_OFS    = 'h100,
    parameter int BANK_STRIDE = 'h10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        boot_swap,
    input  logic                        reg_we,
    input  logic [REG_AW-1:0]           reg_addr,
    input  logic [WORD_W-1:0]           reg_wdata,
    output logic [WORD_W-1:0]           reg_rdata,
    output bank_reg_t [NUM_BANKS-1:0]   banks_o,
    output logic                        swap_o
);

    typedef struct packed {
        bank_reg_t [NUM_BANKS-1:0] bank;
        logic                      swap;
    } regs_state_t;

    regs_state_t st_d, st_q;
    logic [NUM_BANKS-1:0] sel;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_sel
        localparam logic [REG_AW-1:0] OFS = REG_AW'(BANK_OFS + g * BANK_STRIDE);
        assign sel[g] = (reg_addr == OFS);
    end

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.swap = boot_swap;
            for (int i = 0; i < NUM_BANKS; i++) begin
                st_d.bank[i] = '0;
            end
            st_d.bank[0].en = ~boot_swap;
            if (NUM_BANKS > 1) begin
                st_d.bank[1] = to_bank(BANK1_RST);
            end
        end else if (reg_we) begin
            for (int i = 0; i < NUM_BANKS; i++) begin
                if (sel[i]) begin
                    st_d.bank[i] = to_bank(reg_wdata);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (sel[i]) begin
                reg_rdata = reg_rdata | WORD_W'(st_q.bank[i]);
            end
        end
    end

    assign banks_o = st_q.bank;
    assign swap_o  = st_q.swap;

endmodule

// File: rtl/csdec_match.sv
module csdec_match
    import csdec_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int QUIRK_BANKS = 2
) (
    input  bank_reg_t [NUM_BANKS-1:0] banks_i,
    input  logic [WORD_W-1:0]         addr_i,
    output logic [NUM_BANKS-1:0]      hit_o
);

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic in_window;
        assign in_window = window_hit(banks_i[g], addr_i);
        if (g < QUIRK_BANKS) begin : g_quirk
            logic all_zero;
            assign all_zero = (banks_i[g] == '0);
            assign hit_o[g] = all_zero | (banks_i[g].en & in_window);
        end else begin : g_plain
            assign hit_o[g] = banks_i[g].en & in_window;
        end
    end

endmodule

// File: rtl/csdec_select.sv
module csdec_select #(
    parameter int NUM_BANKS = 8
) (
    input  logic                 swap_i,
    input  logic [NUM_BANKS-1:0] hit_i,
    output logic [NUM_BANKS-1:0] grant_o,
    output logic                 any_o
);

    logic [NUM_BANKS-1:0] cs_hit;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_route
        if (g == 0 && NUM_BANKS > 1) begin : g_cs0
            assign cs_hit[g] = swap_i ? hit_i[1] : hit_i[0];
        end else if (g == 1) begin : g_cs1
            assign cs_hit[g] = swap_i ? hit_i[0] : hit_i[1];
        end else begin : g_thru
            assign cs_hit[g] = hit_i[g];
        end
    end

    always_comb begin
        logic taken;
        taken   = 1'b0;
        grant_o = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (cs_hit[i] && !taken) begin
                grant_o[i] = 1'b1;
                taken      = 1'b1;
            end
        end
        any_o = taken;
    end

endmodule

// File: rtl/csdec_top.sv
module csdec_top
    import csdec_pkg::*;
#(
    parameter int NUM_BANKS   = 8,
    parameter int REG_AW      = 12,
    parameter int BANK_OFS    = 'h100,
    parameter int BANK_STRIDE = 'h10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 boot_swap,
    input  logic                 bus_valid,
    input  logic [31:0]          bus_addr,
    input  logic                 reg_we,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic [NUM_BANKS-1:0] cs_o,
    output logic                 no_match_o
);

    typedef struct packed {
        logic [NUM_BANKS-1:0] cs;
        logic                 nm;
    } out_state_t;

    bank_reg_t [NUM_BANKS-1:0] banks_w;
    logic                      swap_w;
    logic [NUM_BANKS-1:0]      hit_w;
    logic [NUM_BANKS-1:0]      grant_w;
    logic                      any_w;
    out_state_t                out_d, out_q;

    csdec_regs #(
        .NUM_BANKS  (NUM_BANKS),
        .REG_AW     (REG_AW),
        .BANK_OFS   (BANK_OFS),
        .BANK_STRIDE(BANK_STRIDE)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .boot_swap(boot_swap),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .banks_o  (banks_w),
        .swap_o   (swap_w)
    );

    csdec_match #(.NUM_BANKS(NUM_BANKS)) match_i (
        .banks_i(banks_w),
        .addr_i (bus_addr),
        .hit_o  (hit_w)
    );

    csdec_select #(.NUM_BANKS(NUM_BANKS)) select_i (
        .swap_i (swap_w),
        .hit_i  (hit_w),
        .grant_o(grant_w),
        .any_o  (any_w)
    );

    always_comb begin
        out_d = '0;
        if (rst_n && bus_valid) begin
            out_d.cs = grant_w;
            out_d.nm = ~any_w;
        end
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign cs_o       = out_q.cs;
    assign no_match_o = out_q.nm;

endmodule

// File: rtl/csdec_chk.sv
module csdec_chk #(
    parameter int NUM_BANKS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_valid,
    input logic [NUM_BANKS-1:0] cs_o,
    input logic                 no_match_o,
    input logic                 swap_q,
    input logic [31:0]          bank0_word
);

    p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_o));

    p_nomatch_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        no_match_o |-> (cs_o == '0));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> (cs_o == '0 && !no_match_o));

    p_strobe_answered_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> ((cs_o != '0) != no_match_o));

    p_strap_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(swap_q));

    p_zero_bank0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bank0_word == 32'h0 && !swap_q) |=> cs_o[0]);

endmodule

bind csdec_top csdec_chk #(.NUM_BANKS(NUM_BANKS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .cs_o      (cs_o),
    .no_match_o(no_match_o),
    .swap_q    (swap_w),
    .bank0_word(32'(banks_w[0]))
);

// File: tb/csdec_top_tb.sv
`timescale 1ns/1ps
module csdec_top_tb_top;

    localparam int NB = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_swap = 1'b0;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NB-1:0] cs_o;
    logic        no_match_o;

    int vectors = 0;
    int miscompares = 0;
    logic [31:0] m_bank [NB];
    logic        m_swap;
    logic [NB-1:0] exp_cs;
    logic        exp_nm;

    always #4 clk = ~clk;

    csdec_top dut_i (
        .clk(clk), .rst_n(rst_n), .boot_swap(boot_swap),
        .bus_valid(bus_valid), .bus_addr(bus_addr),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cs_o(cs_o), .no_match_o(no_match_o)
    );

    function automatic int bank_at(input logic [11:0] a);
        for (int i = 0; i < NB; i++) begin
            if (a == 12'(32'h100 + 32'h10 * i)) return i;
        end
        return -1;
    endfunction

    function automatic logic claims(input int b, input logic [31:0] a);
        logic [31:0] r;
        r = m_bank[b];
        if (b < 2 && r == 32'h0) return 1'b1;
        if (!r[0]) return 1'b0;
        for (int k = 1; k <= 15; k++) begin
            if (r[k] && (a[k+16] != r[k+16])) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic compare(input string tag, input logic [31:0] act,
                           input logic [31:0] exp, input string what);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset(input logic s);
        m_swap = s;
        for (int i = 0; i < NB; i++) m_bank[i] = 32'h0;
        m_bank[0] = {31'h0, ~s};
        m_bank[1] = 32'hFFFE_FFFF;
    endtask

    // drive at a negedge, check reads now and decode one clock later
    task automatic step(input string tag, input logic v, input logic [31:0] a,
                        input logic we, input logic [11:0] ra, input logic [31:0] wd);
        int bi;
        bus_valid = v; bus_addr = a; reg_we = we; reg_addr = ra; reg_wdata = wd;
        #1;
        bi = bank_at(ra);
        compare(tag, reg_rdata, (bi < 0) ? 32'h0 : m_bank[bi], "rdata");
        @(posedge clk);
        exp_cs = '0;
        exp_nm = 1'b0;
        if (v) begin
            exp_nm = 1'b1;
            for (int c = 0; c < NB; c++) begin
                int p;
                p = (m_swap && c < 2) ? 1 - c : c;
                if (exp_nm && claims(p, a)) begin
                    exp_cs[c] = 1'b1;
                    exp_nm = 1'b0;
                end
            end
        end
        if (we && bi >= 0) m_bank[bi] = wd & 32'hFFFE_FFFF;
        @(negedge clk);
        compare(tag, 32'(cs_o), 32'(exp_cs), "cs");
        compare(tag, 32'(no_match_o), 32'(exp_nm), "no_match");
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        rst_n = 1'b0; boot_swap = s; bus_valid = 1'b1; bus_addr = '0; reg_we = 1'b0;
        repeat (3) @(negedge clk);
        compare("R6", 32'(cs_o), 32'h0, "cs in reset");
        compare("R6", 32'(no_match_o), 32'h0, "no_match in reset");
        model_reset(s);
        rst_n = 1'b1;
        bus_valid = 1'b0;
        boot_swap = ~s;
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < NB; i++) step(tag, 1'b0, 32'h0, 1'b0, 12'(32'h100 + 32'h10 * i), 32'h0);
    endtask

    initial begin
        fork
            begin
                do_reset(1'b0);
                read_all("R6");
                // R2: bank 0 full window after reset, low bits ignored
                step("R2", 1'b1, 32'h2000_0000, 1'b0, 12'h0, 32'h0);
                step("R7", 1'b1, 32'hFFFF_0000, 1'b0, 12'h0, 32'h0);
                // R1: store, bit 16 cleared on read
                step("R1", 1'b0, 32'h0, 1'b1, 12'h100, 32'hFFFF_FFFF);
                step("R1", 1'b0, 32'h0, 1'b1, 12'h120, 32'h1001_FF01);
                read_all("R1");
                step("R2", 1'b1, 32'h1012_3456, 1'b0, 12'h0, 32'h0);
                step("R2", 1'b1, 32'h1000_0000, 1'b0, 12'h0, 32'h0);
                step("R2", 1'b1, 32'h10FF_FFFF, 1'b0, 12'h0, 32'h0);
                step("R8", 1'b1, 32'h1100_0000, 1'b0, 12'h0, 32'h0);
                step("R8", 1'b1, 32'h0000_0000, 1'b0, 12'h0, 32'h0);
                // R7: overlapping 128 KiB window on bank 3
                step("R7", 1'b0, 32'h0, 1'b1, 12'h130, 32'h1002_FFFF);
                step("R7", 1'b1, 32'h1002_1234, 1'b0, 12'h0, 32'h0);
                step("R2", 1'b1, 32'h1004_0000, 1'b0, 12'h0, 32'h0);
                // R3: bank 2 disabled but nonzero, R10 same-cycle write
                step("R10", 1'b1, 32'h1002_0000, 1'b1, 12'h120, 32'h1000_FF00);
                step("R3", 1'b1, 32'h1002_0000, 1'b0, 12'h0, 32'h0);
                step("R3", 1'b1, 32'h1012_0000, 1'b0, 12'h0, 32'h0);
                // R2: enabled bank with empty mask claims all
                step("R2", 1'b0, 32'h0, 1'b1, 12'h140, 32'h2000_0001);
                step("R7", 1'b1, 32'h1002_0000, 1'b0, 12'h0, 32'h0);
                step("R2", 1'b1, 32'h5555_5555, 1'b0, 12'h0, 32'h0);
                step("R3", 1'b0, 32'h0, 1'b1, 12'h140, 32'h2000_0000);
                // R1: unmapped offsets
                step("R1", 1'b0, 32'h0, 1'b1, 12'h104, 32'h1234_5678);
                step("R1", 1'b0, 32'h0, 1'b1, 12'h180, 32'h0000_0001);
                step("R1", 1'b1, 32'h7000_0000, 1'b0, 12'h104, 32'h0);
                read_all("R1");
                // R4: zero bank 0 / bank 1 capture
                step("R4", 1'b0, 32'h0, 1'b1, 12'h100, 32'h0);
                step("R4", 1'b1, 32'h1002_0000, 1'b0, 12'h0, 32'h0);
                step("R4", 1'b1, 32'hFFFF_FFFF, 1'b0, 12'h0, 32'h0);
                step("R4", 1'b0, 32'h0, 1'b1, 12'h100, 32'h0001_0000);
                step("R4", 1'b0, 32'h0, 1'b1, 12'h110, 32'h0);
                step("R4", 1'b1, 32'h1002_0000, 1'b0, 12'h100, 32'h0);
                step("R4", 1'b0, 32'h0, 1'b1, 12'h100, 32'hFFFF_FFFF);
                step("R4", 1'b1, 32'hFFFF_0000, 1'b0, 12'h0, 32'h0);
                step("R4", 1'b1, 32'h3000_0000, 1'b0, 12'h0, 32'h0);
                // R9: idle cycles
                step("R9", 1'b0, 32'h3000_0000, 1'b0, 12'h0, 32'h0);
                step("R9", 1'b1, 32'h3000_0000, 1'b0, 12'h0, 32'h0);
                step("R9", 1'b0, 32'h1002_0000, 1'b0, 12'h0, 32'h0);
                // R5: strap set
                do_reset(1'b1);
                read_all("R6");
                step("R5", 1'b1, 32'h0000_0000, 1'b0, 12'h0, 32'h0);
                step("R5", 1'b1, 32'hFFFF_FFF0, 1'b0, 12'h0, 32'h0);
                step("R5", 1'b0, 32'h0, 1'b1, 12'h110, 32'h1000_FF01);
                step("R5", 1'b0, 32'h0, 1'b1, 12'h100, 32'h4000_C001);
                step("R5", 1'b1, 32'h1000_0000, 1'b0, 12'h0, 32'h0);
                step("R5", 1'b1, 32'h4123_0000, 1'b0, 12'h0, 32'h0);
                step("R8", 1'b1, 32'h8000_0000, 1'b0, 12'h0, 32'h0);
                step("R5", 1'b0, 32'h0, 1'b1, 12'h100, 32'h0);
                step("R5", 1'b1, 32'h8000_0000, 1'b0, 12'h0, 32'h0);
                step("R5", 1'b1, 32'h1000_0000, 1'b0, 12'h0, 32'h0);
            end
            begin
                repeat (200000) @(posedge clk);
                miscompares++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule